// File: doc/BRIEF.md
# Parallel Camera Sync-Mode Pixel Capture

This block takes pixels from a progressive-scan image sensor that marks lines and frames with separate horizontal and vertical sync wires. It samples a twelve-line data bus together with the two syncs, a field line and an optional write-enable on the sensor's pixel clock. Each sync wire has its own polarity setting, so the logic that follows sees only active-high levels.

A pixel is taken only while both syncs are active and, when write-enable qualification is on, write-enable is active too. The pixel is selected from the bus by a lane shift of 0, 2 or 4 lines, and then masked to a width of 8, 10, 11 or 12 bits. A shift that does not suit the chosen width falls back to no shift and sets a sticky error flag. Accepted pixels come out in order as a stream with valid, start-of-frame and end-of-line flags. Each pixel is held back until the next one arrives or the line closes, so the last pixel of a line can carry its end-of-line flag. The field level seen when vertical sync rises is held for the rest of the frame. Pixel and line counters restart at every frame start.

Top module: `cam_sync_capture`

## Requirements
- R1: While reset is asserted, and at the first edge after it, pix_valid, pix_sof, pix_eol, frame_field, line_pixels, frame_lines and cfg_error are all zero.
- R2: The pixel is (bus >> 2*k) masked to the width, with cfg_width 0/1/2/3 = 8/10/11/12 bits and cfg_shift 0/1/2 = k of 0/1/2 (that is 0, 2 or 4 lanes).
- R3: Bus bits above the selected width never reach pix_data. Every emitted pixel is below 2^width.
- R4: Shift 1 is legal only with 10-bit width, and shift 2 only with 8-bit width. Any other non-zero shift, including code 3, is applied as shift 0 and sets cfg_error, which stays at 1 until reset.
- R5: No pixel is accepted unless horizontal and vertical sync are both at their active level.
- R6: With cfg_wen_use=1, a pixel also needs write-enable active. With cfg_wen_use=0, the write-enable input has no effect.
- R7: cfg_hs_low, cfg_vs_low and cfg_fld_low each set their signal as active-low when 1 and active-high when 0.
- R8: pix_sof is set on exactly the first accepted pixel after vertical sync becomes active.
- R9: pix_eol is set on exactly the last accepted pixel before horizontal sync (or vertical sync) goes inactive.
- R10: frame_field takes the normalized field level seen in the same sample as the rising edge of vertical sync, and holds it until the next rising edge.
- R11: line_pixels counts the accepted pixels of the current line, and frame_lines counts the lines closed with end-of-line. Both clear to zero when vertical sync rises.
- R12: Pixels come out in acceptance order, none lost or duplicated, each delayed until the following pixel or the line end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sensor pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | 2 | Pixel width code: 0=8, 1=10, 2=11, 3=12 bits |
| cfg_shift | input | 2 | Lane shift code: 0=none, 1=2 lanes, 2=4 lanes |
| cfg_hs_low | input | 1 | Horizontal sync is active low |
| cfg_vs_low | input | 1 | Vertical sync is active low |
| cfg_fld_low | input | 1 | Field is active low |
| cfg_wen_use | input | 1 | Qualify pixels with write-enable |
| cam_data | input | BUS_W | Sensor data lines |
| cam_hs | input | 1 | Horizontal sync |
| cam_vs | input | 1 | Vertical sync |
| cam_fld | input | 1 | Field indicator |
| cam_wen | input | 1 | External write-enable |
| pix_data | output | BUS_W | Selected pixel, zero-extended |
| pix_valid | output | 1 | Pixel strobe |
| pix_sof | output | 1 | First pixel of the frame |
| pix_eol | output | 1 | Last pixel of the line |
| frame_field | output | 1 | Field level latched at frame start |
| cfg_error | output | 1 | Sticky illegal shift/width combination |
| line_pixels | output | CNT_W | Accepted pixels in the current line |
| frame_lines | output | CNT_W | Completed lines in the current frame |

## Verification
Inputs are sampled into a capture register at the first rising edge. The accept decision and the holding register act at the second edge. So a pixel appears on the outputs two edges after the next accepted pixel is driven, or two edges after horizontal sync is driven inactive. frame_field and both counters settle at that same second edge. The bench compares the emitted stream against an in-order queue of expected pixels and flags, filled as stimulus is driven. Outputs are observed on falling edges, and counters, field and error flag are read only after enough blanking cycles for every pending result to be due. The sweep covers every width and shift code, with polarities, write-enable use and write-enable gaps varied across the configurations.

// File: rtl/cam_cap_pkg.sv
package cam_cap_pkg;

   typedef enum logic [1:0] {
      PW_8  = 2'd0,
      PW_10 = 2'd1,
      PW_11 = 2'd2,
      PW_12 = 2'd3
   } pix_width_e;

   typedef enum logic [1:0] {
      LS_NONE = 2'd0,
      LS_TWO  = 2'd1,
      LS_FOUR = 2'd2,
      LS_RSVD = 2'd3
   } lane_shift_e;

   // normalized (active-high) sync levels
   typedef struct packed {
      logic hs;
      logic vs;
      logic fld;
      logic wen;
   } sync_lvl_t;

   localparam int unsigned LANE_STEP = 2;
   localparam int unsigned MIN_BUS_W = 12;

   function automatic logic shift_legal(input logic [1:0] w, input logic [1:0] s);
      return (s == LS_NONE) ||
             ((s == LS_TWO)  && (w == PW_10)) ||
             ((s == LS_FOUR) && (w == PW_8));
   endfunction

   function automatic int unsigned width_bits(input logic [1:0] w);
      case (w)
         PW_8:    return 8;
         PW_10:   return 10;
         PW_11:   return 11;
         default: return 12;
      endcase
   endfunction

endpackage

// File: rtl/cam_cap_sync_norm.sv
module cam_cap_sync_norm
   import cam_cap_pkg::*;
#(
   parameter int unsigned BUS_W       = 12,
   parameter bit          SAMPLE_FALL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pol_hs_low,
   input  logic             pol_vs_low,
   input  logic             pol_fld_low,
   input  logic [BUS_W-1:0] raw_data,
   input  logic             raw_hs,
   input  logic             raw_vs,
   input  logic             raw_fld,
   input  logic             raw_wen,
   output logic [BUS_W-1:0] cap_data,
   output sync_lvl_t        cap_sync
);

   sync_lvl_t lvl_in;

   always_comb begin
      lvl_in.hs  = raw_hs  ^ pol_hs_low;
      lvl_in.vs  = raw_vs  ^ pol_vs_low;
      lvl_in.fld = raw_fld ^ pol_fld_low;
      lvl_in.wen = raw_wen;
   end

   generate
      if (SAMPLE_FALL) begin : g_fall
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cap_data <= '0;
               cap_sync <= '0;
            end else begin
               cap_data <= raw_data;
               cap_sync <= lvl_in;
            end
         end
      end else begin : g_rise
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cap_data <= '0;
               cap_sync <= '0;
            end else begin
               cap_data <= raw_data;
               cap_sync <= lvl_in;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/cam_cap_lane_sel.sv
module cam_cap_lane_sel
   import cam_cap_pkg::*;
#(
   parameter int unsigned BUS_W = 12
) (
   input  logic [BUS_W-1:0] bus,
   input  logic [1:0]       width_code,
   input  logic [1:0]       shift_code,
   output logic [BUS_W-1:0] pixel,
   output logic             combo_bad
);

   localparam int unsigned SH_W = $clog2(LANE_STEP * 3 + 1);

   logic             legal;
   logic [1:0]       eff_shift;
   logic [SH_W-1:0]  sh_amt;
   logic [BUS_W-1:0] shifted;
   logic [BUS_W-1:0] mask;

   always_comb begin
      legal     = shift_legal(width_code, shift_code);
      combo_bad = ~legal;
      eff_shift = legal ? shift_code : LS_NONE;
      sh_amt    = SH_W'(LANE_STEP) * SH_W'(eff_shift);
      shifted   = bus >> sh_amt;
   end

   always_comb begin
      case (width_code)
         PW_8:    mask = BUS_W'({8{1'b1}});
         PW_10:   mask = BUS_W'({10{1'b1}});
         PW_11:   mask = BUS_W'({11{1'b1}});
         default: mask = BUS_W'({12{1'b1}});
      endcase
   end

   assign pixel = shifted & mask;

endmodule

// File: rtl/cam_cap_line_track.sv
module cam_cap_line_track
   import cam_cap_pkg::*;
#(
   parameter int unsigned BUS_W = 12,
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wen_use,
   input  sync_lvl_t        lvl,
   input  logic [BUS_W-1:0] pixel,
   output logic [BUS_W-1:0] out_data,
   output logic             out_valid,
   output logic             out_sof,
   output logic             out_eol,
   output logic             field_q,
   output logic [CNT_W-1:0] pix_cnt,
   output logic [CNT_W-1:0] line_cnt
);

   logic             hs_q, vs_q;
   logic             hold_v, hold_sof;
   logic [BUS_W-1:0] hold_d;
   logic             sof_pend;

   logic accept, vs_rise, hs_rise, flush, sof_now;

   always_comb begin
      accept  = lvl.hs & lvl.vs & (lvl.wen | ~wen_use);
      vs_rise = lvl.vs & ~vs_q;
      hs_rise = lvl.hs & ~hs_q;
      flush   = hold_v & ~(lvl.hs & lvl.vs);
      sof_now = sof_pend | vs_rise;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_q      <= 1'b0;
         vs_q      <= 1'b0;
         hold_v    <= 1'b0;
         hold_sof  <= 1'b0;
         hold_d    <= '0;
         sof_pend  <= 1'b0;
         out_data  <= '0;
         out_valid <= 1'b0;
         out_sof   <= 1'b0;
         out_eol   <= 1'b0;
         field_q   <= 1'b0;
      end else begin
         hs_q      <= lvl.hs;
         vs_q      <= lvl.vs;
         out_valid <= 1'b0;
         out_sof   <= 1'b0;
         out_eol   <= 1'b0;
         if (accept) begin
            if (hold_v) begin
               out_valid <= 1'b1;
               out_data  <= hold_d;
               out_sof   <= hold_sof;
            end
            hold_v   <= 1'b1;
            hold_d   <= pixel;
            hold_sof <= sof_now;
         end else if (flush) begin
            out_valid <= 1'b1;
            out_data  <= hold_d;
            out_sof   <= hold_sof;
            out_eol   <= 1'b1;
            hold_v    <= 1'b0;
            hold_sof  <= 1'b0;
         end
         if (accept)
            sof_pend <= 1'b0;
         else if (vs_rise)
            sof_pend <= 1'b1;
         if (vs_rise)
            field_q <= lvl.fld;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_cnt  <= '0;
         line_cnt <= '0;
      end else begin
         if (vs_rise || hs_rise)
            pix_cnt <= accept ? CNT_W'(1) : '0;
         else if (accept)
            pix_cnt <= pix_cnt + 1'b1;
         if (vs_rise)
            line_cnt <= '0;
         else if (!accept && flush)
            line_cnt <= line_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/cam_sync_capture.sv
module cam_sync_capture
   import cam_cap_pkg::*;
#(
   parameter int unsigned BUS_W       = 12,
   parameter int unsigned CNT_W       = 16,
   parameter bit          SAMPLE_FALL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       cfg_width,
   input  logic [1:0]       cfg_shift,
   input  logic             cfg_hs_low,
   input  logic             cfg_vs_low,
   input  logic             cfg_fld_low,
   input  logic             cfg_wen_use,
   input  logic [BUS_W-1:0] cam_data,
   input  logic             cam_hs,
   input  logic             cam_vs,
   input  logic             cam_fld,
   input  logic             cam_wen,
   output logic [BUS_W-1:0] pix_data,
   output logic             pix_valid,
   output logic             pix_sof,
   output logic             pix_eol,
   output logic             frame_field,
   output logic             cfg_error,
   output logic [CNT_W-1:0] line_pixels,
   output logic [CNT_W-1:0] frame_lines
);

   generate
      if (BUS_W < MIN_BUS_W) begin : g_bad_bus
         $error("cam_sync_capture: BUS_W must be at least 12");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("cam_sync_capture: CNT_W must be at least 2");
      end
   endgenerate

   logic [BUS_W-1:0] cap_data;
   sync_lvl_t        cap_sync;
   logic [BUS_W-1:0] sel_pixel;
   logic             combo_bad;

   cam_cap_sync_norm #(
      .BUS_W       (BUS_W),
      .SAMPLE_FALL (SAMPLE_FALL)
   ) u_norm (
      .clk         (clk),
      .rst_n       (rst_n),
      .pol_hs_low  (cfg_hs_low),
      .pol_vs_low  (cfg_vs_low),
      .pol_fld_low (cfg_fld_low),
      .raw_data    (cam_data),
      .raw_hs      (cam_hs),
      .raw_vs      (cam_vs),
      .raw_fld     (cam_fld),
      .raw_wen     (cam_wen),
      .cap_data    (cap_data),
      .cap_sync    (cap_sync)
   );

   cam_cap_lane_sel #(
      .BUS_W (BUS_W)
   ) u_sel (
      .bus        (cap_data),
      .width_code (cfg_width),
      .shift_code (cfg_shift),
      .pixel      (sel_pixel),
      .combo_bad  (combo_bad)
   );

   cam_cap_line_track #(
      .BUS_W (BUS_W),
      .CNT_W (CNT_W)
   ) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .wen_use   (cfg_wen_use),
      .lvl       (cap_sync),
      .pixel     (sel_pixel),
      .out_data  (pix_data),
      .out_valid (pix_valid),
      .out_sof   (pix_sof),
      .out_eol   (pix_eol),
      .field_q   (frame_field),
      .pix_cnt   (line_pixels),
      .line_cnt  (frame_lines)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cfg_error <= 1'b0;
      else if (combo_bad)
         cfg_error <= 1'b1;
   end

endmodule

// File: rtl/cam_sync_capture_chk.sv
module cam_sync_capture_chk #(
   parameter int unsigned BUS_W = 12,
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       cfg_width,
   input logic [BUS_W-1:0] pix_data,
   input logic             pix_valid,
   input logic             pix_sof,
   input logic             pix_eol,
   input logic             cfg_error,
   input logic [CNT_W-1:0] frame_lines
);

   logic [BUS_W-1:0] lim_mask;
   always_comb begin
      case (cfg_width)
         2'd0:    lim_mask = BUS_W'({8{1'b1}});
         2'd1:    lim_mask = BUS_W'({10{1'b1}});
         2'd2:    lim_mask = BUS_W'({11{1'b1}});
         default: lim_mask = BUS_W'({12{1'b1}});
      endcase
   end

   assert_sof_with_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pix_sof |-> pix_valid);

   assert_eol_with_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pix_eol |-> pix_valid);

   assert_error_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_error |=> cfg_error);

   assert_pixel_in_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |-> ((pix_data & ~lim_mask) == '0));

   assert_line_count_on_eol_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ((frame_lines != $past(frame_lines)) && (frame_lines != '0)) |-> pix_eol);

endmodule

bind cam_sync_capture cam_sync_capture_chk #(
   .BUS_W (BUS_W),
   .CNT_W (CNT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_width   (cfg_width),
   .pix_data    (pix_data),
   .pix_valid   (pix_valid),
   .pix_sof     (pix_sof),
   .pix_eol     (pix_eol),
   .cfg_error   (cfg_error),
   .frame_lines (frame_lines)
);

// File: tb/cam_sync_capture_test.sv
module cam_sync_capture_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_width = 2'd0;
   logic [1:0]  cfg_shift = 2'd0;
   logic        cfg_hs_low = 1'b0, cfg_vs_low = 1'b0, cfg_fld_low = 1'b0, cfg_wen_use = 1'b0;
   logic [11:0] cam_data = '0;
   logic        cam_hs = 1'b0, cam_vs = 1'b0, cam_fld = 1'b0, cam_wen = 1'b0;
   logic [11:0] pix_data;
   logic        pix_valid, pix_sof, pix_eol, frame_field, cfg_error;
   logic [15:0] line_pixels, frame_lines;

   int vectors = 0;
   int fails   = 0;
   bit finished = 1'b0;

   typedef struct packed {
      logic [11:0] d;
      logic        sof;
      logic        eol;
   } exp_t;
   exp_t exq[$];

   always #2 clk = ~clk;

   cam_sync_capture uut (
      .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_shift(cfg_shift),
      .cfg_hs_low(cfg_hs_low), .cfg_vs_low(cfg_vs_low), .cfg_fld_low(cfg_fld_low),
      .cfg_wen_use(cfg_wen_use), .cam_data(cam_data), .cam_hs(cam_hs), .cam_vs(cam_vs),
      .cam_fld(cam_fld), .cam_wen(cam_wen), .pix_data(pix_data), .pix_valid(pix_valid),
      .pix_sof(pix_sof), .pix_eol(pix_eol), .frame_field(frame_field), .cfg_error(cfg_error),
      .line_pixels(line_pixels), .frame_lines(frame_lines)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
      vectors++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   function automatic logic legal(input logic [1:0] w, input logic [1:0] s);
      return (s == 2'd0) || (s == 2'd1 && w == 2'd1) || (s == 2'd2 && w == 2'd0);
   endfunction

   function automatic logic [11:0] exp_pix(input logic [11:0] d, input logic [1:0] w, input logic [1:0] s);
      int sh;
      int bits;
      sh   = legal(w, s) ? 2 * s : 0;
      bits = (w == 2'd0) ? 8 : (w == 2'd1) ? 10 : (w == 2'd2) ? 11 : 12;
      return 12'((32'(d) >> sh) & ((32'd1 << bits) - 1));
   endfunction

   // stream monitor: R2, R8, R9, R12
   always @(negedge clk) begin
      if (rst_n && pix_valid) begin
         if (exq.size() == 0) begin
            check("R12 unexpected pixel", {20'd0, pix_data}, 32'hFFFF_FFFF);
         end else begin
            exp_t e;
            e = exq.pop_front();
            check("R2 pixel value", {20'd0, pix_data}, {20'd0, e.d});
            check("R8 sof flag", {31'd0, pix_sof}, {31'd0, e.sof});
            check("R9 eol flag", {31'd0, pix_eol}, {31'd0, e.eol});
         end
      end
   end

   // one pin cycle, levels given as active-high
   task automatic drive(input logic hs, input logic vs, input logic fld,
                        input logic wen, input logic [11:0] d);
      @(negedge clk);
      cam_hs   = hs  ^ cfg_hs_low;
      cam_vs   = vs  ^ cfg_vs_low;
      cam_fld  = fld ^ cfg_fld_low;
      cam_wen  = wen;
      cam_data = d;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n   = 1'b0;
      cam_hs  = cfg_hs_low;
      cam_vs  = cfg_vs_low;
      cam_fld = cfg_fld_low;
      cam_wen = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // frame of nl lines by np pixels; gaps adds write-enable idle cycles
   task automatic run_frame(input int nl, input int np, input bit gaps,
                            input logic fld, input int seed);
      repeat (3) drive(1'b0, 1'b0, ~fld, 1'b0, 12'hFFF);
      // R5: horizontal sync alone, vertical inactive, carries no pixel
      repeat (2) drive(1'b1, 1'b0, ~fld, 1'b1, 12'hABC);
      drive(1'b0, 1'b1, fld, 1'b0, 12'h0);
      drive(1'b0, 1'b1, ~fld, 1'b1, 12'h5A5);
      for (int l = 0; l < nl; l++) begin
         for (int x = 0; x < np; x++) begin
            logic [11:0] d;
            d = 12'((l * 419) + (x * 709) + (seed * 241) + 12'h8F0);
            if (gaps && cfg_wen_use)
               drive(1'b1, 1'b1, ~fld, 1'b0, ~d);   // R6: ignored by qualification
            exq.push_back('{d: exp_pix(d, cfg_width, cfg_shift),
                            sof: (l == 0 && x == 0), eol: (x == np - 1)});
            drive(1'b1, 1'b1, ~fld, cfg_wen_use | ~gaps, d);
         end
         repeat (3) drive(1'b0, 1'b1, ~fld, 1'b1, 12'h3C3);
      end
      repeat (3) drive(1'b0, 1'b0, ~fld, 1'b0, 12'h0);
      check("R12 queue drained", 32'(exq.size()), 32'd0);
      check("R10 frame field", {31'd0, frame_field}, {31'd0, fld});
      check("R11 frame lines", {16'd0, frame_lines}, 32'(nl));
      check("R11 line pixels", {16'd0, line_pixels}, 32'(np));
   endtask

   initial begin
      #(4 * 150000);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1: reset state at first edge after release
      @(negedge clk);
      check("R1 valid", {31'd0, pix_valid}, 32'd0);
      check("R1 error", {31'd0, cfg_error}, 32'd0);
      check("R1 field", {31'd0, frame_field}, 32'd0);
      check("R1 counts", {frame_lines, line_pixels}, 32'd0);

      // sweep every width/shift code, varying polarity (R7) and write-enable (R6)
      for (int w = 0; w < 4; w++) begin
         for (int s = 0; s < 4; s++) begin
            cfg_width   = 2'(w);
            cfg_shift   = 2'(s);
            cfg_hs_low  = 1'(w ^ s);
            cfg_vs_low  = 1'(s >> 1);
            cfg_fld_low = 1'(w >> 1);
            cfg_wen_use = 1'(s);
            do_reset();
            run_frame(2, 3, 1'(w), 1'((w + s) & 1), w * 4 + s);
            // R4: sticky error only for illegal combination
            check("R4 config error", {31'd0, cfg_error}, {31'd0, ~legal(2'(w), 2'(s))});
         end
      end

      // longer 12-bit frame, write-enable unused and held inactive (R6)
      cfg_width = 2'd3; cfg_shift = 2'd0; cfg_wen_use = 1'b0;
      cfg_hs_low = 1'b1; cfg_vs_low = 1'b1; cfg_fld_low = 1'b0;
      do_reset();
      run_frame(4, 16, 1'b1, 1'b1, 99);
      // second frame on same reset: counters and field restart (R11, R10)
      run_frame(3, 5, 1'b0, 1'b0, 7);
      // R11: counters clear on vertical sync rise alone
      drive(1'b0, 1'b1, 1'b0, 1'b0, 12'h0);
      repeat (3) drive(1'b0, 1'b1, 1'b0, 1'b0, 12'h0);
      check("R11 lines cleared", {16'd0, frame_lines}, 32'd0);
      check("R11 pixels cleared", {16'd0, line_pixels}, 32'd0);
      repeat (3) drive(1'b0, 1'b0, 1'b0, 1'b0, 12'h0);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule